// File: doc/BRIEF.md
# Extended-Mode Data Address Generator

This block resolves the 12-bit data memory address used by a byte-oriented or bit-oriented instruction of an 8-bit microcontroller core running with its extended instruction set switched on. It reads the 16-bit instruction word and takes two fields from it: the 8-bit file operand in bits 7:0 and the access-select bit in bit 8. Together these two fields pick one of three ways to form the address.

- With the access bit set, the address is a banked address: the 4-bit bank register on top and the file operand below it.
- With the access bit clear and an operand of 60h or more, the address falls in the upper access window in bank 15 (F60h to FFFh). This is where the special function registers live.
- With the access bit clear and an operand of 5Fh or less, the operand is an unsigned offset added to a 12-bit pointer. The sum wraps within the 4 KB space.

The block also holds the bank register and the pointer. The pointer has a 4-bit high half and an 8-bit low half, and each of the three registers has its own synchronous load port. The address path is purely combinational, so a register load is seen by the next instruction and not by the one presented in the cycle of the load. The data here is a single instruction word that resolves in the same cycle. There is no stream to pace, so every pin is a plain level with no valid/ready handshake.

Top module: `ext_data_addr_gen`

## Requirements
- R1: When instr[8] is 1, for any operand, addr equals {bank, instr[7:0]}, mode is 2'b00 (direct) and indexed is 0.
- R2: When instr[8] is 0 and instr[7:0] is 60h or greater, addr equals {4'hF, instr[7:0]}, mode is 2'b01 (forced window) and indexed is 0.
- R3: When instr[8] is 0 and instr[7:0] is 5Fh or less, addr equals pointer + instr[7:0], mode is 2'b10 (indexed offset) and indexed is 1.
- R4: The pointer-plus-offset sum is truncated to 12 bits, so it wraps past FFFh to the bottom of the space.
- R5: After reset the bank register and both pointer halves are zero.
- R6: A load presented with its enable high takes effect at the next rising clock edge. The address in the cycle of the load still uses the old value, and a register whose enable is low keeps its value.
- R7: Instruction bits 15:9, which hold the opcode and the destination bit, have no effect on addr, mode or indexed.
- R8: The pointer high half (4 bits) and low half (8 bits) load independently, so pointer = {ptr_hi, ptr_lo}.
- R9: indexed is 1 exactly when mode is 2'b10, and mode never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset for the registers |
| instr | input | 16 | Current instruction word |
| bank_we | input | 1 | Load enable for the bank register |
| bank_wdata | input | 4 | New bank value |
| ptr_hi_we | input | 1 | Load enable for the pointer high half |
| ptr_hi_wdata | input | 4 | New pointer high half |
| ptr_lo_we | input | 1 | Load enable for the pointer low half |
| ptr_lo_wdata | input | 8 | New pointer low half |
| addr | output | 12 | Resolved data address |
| mode | output | 2 | 00 direct, 01 forced window, 10 indexed offset |
| indexed | output | 1 | High in indexed offset mode |

## Verification
The bench targets the threshold between operands 5Fh and 60h with the access bit clear. A design that put the compare one value off would send one of these operands into the wrong mode, and the address would jump between the window in bank 15 and the pointer region. Pointer values near FFFh with large offsets check the wraparound, where a design that kept a carry or saturated would give the wrong address. Loads are made in the same cycle as a check, and random enables are left low, so a design that passed the new value straight through, or that loaded without its enable, shows a stale or early address. Random opcode and destination bits test that only bits 8:0 steer the result.

// File: rtl/eadg_pkg.sv
package eadg_pkg;
  typedef enum logic [1:0] {
    MODE_DIRECT  = 2'b00,
    MODE_FORCED  = 2'b01,
    MODE_INDEXED = 2'b10
  } eadg_mode_e;
endpackage

// File: rtl/eadg_regs.sv
module eadg_regs #(
  parameter int ADDR_W = 12,
  parameter int F_W    = 8,
  localparam int HI_W  = ADDR_W - F_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_we,
  input  logic [HI_W-1:0]   bank_wdata,
  input  logic              ptr_hi_we,
  input  logic [HI_W-1:0]   ptr_hi_wdata,
  input  logic              ptr_lo_we,
  input  logic [F_W-1:0]    ptr_lo_wdata,
  output logic [HI_W-1:0]   bank_q,
  output logic [ADDR_W-1:0] ptr_q
);
  logic [HI_W-1:0] ptr_hi_q;
  logic [F_W-1:0]  ptr_lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q   <= '0;
      ptr_hi_q <= '0;
      ptr_lo_q <= '0;
    end else begin
      if (bank_we)   bank_q   <= bank_wdata;
      if (ptr_hi_we) ptr_hi_q <= ptr_hi_wdata;
      if (ptr_lo_we) ptr_lo_q <= ptr_lo_wdata;
    end
  end

  assign ptr_q = {ptr_hi_q, ptr_lo_q};
endmodule

// File: rtl/eadg_decode.sv
module eadg_decode
  import eadg_pkg::*;
#(
  parameter int              F_W       = 8,
  parameter logic [F_W-1:0]  FORCED_LO = 8'h60
) (
  input  logic           acc_bit,
  input  logic [F_W-1:0] operand,
  output eadg_mode_e     mode,
  output logic           indexed
);
  always_comb begin
    if (acc_bit)                   mode = MODE_DIRECT;
    else if (operand >= FORCED_LO) mode = MODE_FORCED;
    else                           mode = MODE_INDEXED;
  end

  assign indexed = (mode == MODE_INDEXED);
endmodule

// File: rtl/eadg_addr.sv
module eadg_addr
  import eadg_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int F_W    = 8,
  localparam int HI_W  = ADDR_W - F_W
) (
  input  eadg_mode_e        mode,
  input  logic [F_W-1:0]    operand,
  input  logic [HI_W-1:0]   bank,
  input  logic [ADDR_W-1:0] ptr,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] offset_ext;
  logic [ADDR_W-1:0] sum;

  assign offset_ext = {{HI_W{1'b0}}, operand};
  assign sum        = ptr + offset_ext;

  always_comb begin
    unique case (mode)
      MODE_DIRECT:  addr = {bank, operand};
      MODE_FORCED:  addr = {{HI_W{1'b1}}, operand};
      MODE_INDEXED: addr = sum;
      default:      addr = '0;
    endcase
  end
endmodule

// File: rtl/ext_data_addr_gen.sv
module ext_data_addr_gen
  import eadg_pkg::*;
#(
  parameter int              INSTR_W   = 16,
  parameter int              ADDR_W    = 12,
  parameter int              F_W       = 8,
  parameter int              ACC_BIT   = 8,
  parameter logic [F_W-1:0]  FORCED_LO = 8'h60,
  localparam int             HI_W      = ADDR_W - F_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] instr,
  input  logic               bank_we,
  input  logic [HI_W-1:0]    bank_wdata,
  input  logic               ptr_hi_we,
  input  logic [HI_W-1:0]    ptr_hi_wdata,
  input  logic               ptr_lo_we,
  input  logic [F_W-1:0]     ptr_lo_wdata,
  output logic [ADDR_W-1:0]  addr,
  output logic [1:0]         mode,
  output logic               indexed
);
  logic [HI_W-1:0]   bank_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [F_W-1:0]    operand;
  logic              acc_bit;
  eadg_mode_e        mode_e;

  assign operand = instr[F_W-1:0];
  assign acc_bit = instr[ACC_BIT];

  eadg_regs #(.ADDR_W(ADDR_W), .F_W(F_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bank_we(bank_we), .bank_wdata(bank_wdata),
    .ptr_hi_we(ptr_hi_we), .ptr_hi_wdata(ptr_hi_wdata),
    .ptr_lo_we(ptr_lo_we), .ptr_lo_wdata(ptr_lo_wdata),
    .bank_q(bank_q), .ptr_q(ptr_q)
  );

  eadg_decode #(.F_W(F_W), .FORCED_LO(FORCED_LO)) u_decode (
    .acc_bit(acc_bit), .operand(operand),
    .mode(mode_e), .indexed(indexed)
  );

  eadg_addr #(.ADDR_W(ADDR_W), .F_W(F_W)) u_addr (
    .mode(mode_e), .operand(operand), .bank(bank_q), .ptr(ptr_q),
    .addr(addr)
  );

  assign mode = mode_e;
endmodule

// File: rtl/ext_data_addr_gen_chk.sv
module ext_data_addr_gen_chk #(
  parameter int ADDR_W = 12,
  parameter int F_W    = 8,
  parameter int HI_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_bit,
  input logic [F_W-1:0]    operand,
  input logic              bank_we,
  input logic [HI_W-1:0]   bank_q,
  input logic [ADDR_W-1:0] ptr_q,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        mode,
  input logic              indexed
);
  AST_DIRECT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    acc_bit |-> (addr == {bank_q, operand}) && (mode == 2'b00)); // R1
  AST_FORCED_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_bit && operand >= 8'h60) |-> (addr[ADDR_W-1:F_W] == {HI_W{1'b1}}) && (mode == 2'b01)); // R2
  AST_INDEXED_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_bit && operand < 8'h60) |-> (addr == ADDR_W'(ptr_q + {{HI_W{1'b0}}, operand})) && indexed); // R3
  AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (indexed == (mode == 2'b10)) && (mode != 2'b11)); // R9
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_we |=> $stable(bank_q)); // R6
endmodule

bind ext_data_addr_gen ext_data_addr_gen_chk #(.ADDR_W(ADDR_W), .F_W(F_W), .HI_W(HI_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_bit(acc_bit), .operand(operand),
  .bank_we(bank_we), .bank_q(bank_q), .ptr_q(ptr_q),
  .addr(addr), .mode(mode), .indexed(indexed)
);

// File: tb/ext_data_addr_gen_tb.sv
`timescale 1ns/1ps
module ext_data_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr = '0;
  logic        bank_we = 1'b0;
  logic [3:0]  bank_wdata = '0;
  logic        ptr_hi_we = 1'b0;
  logic [3:0]  ptr_hi_wdata = '0;
  logic        ptr_lo_we = 1'b0;
  logic [7:0]  ptr_lo_wdata = '0;
  logic [11:0] addr;
  logic [1:0]  mode;
  logic        indexed;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [3:0] m_bank = '0;
  logic [3:0] m_hi = '0;
  logic [7:0] m_lo = '0;

  always #2.5 clk = ~clk;

  ext_data_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .instr(instr),
    .bank_we(bank_we), .bank_wdata(bank_wdata),
    .ptr_hi_we(ptr_hi_we), .ptr_hi_wdata(ptr_hi_wdata),
    .ptr_lo_we(ptr_lo_we), .ptr_lo_wdata(ptr_lo_wdata),
    .addr(addr), .mode(mode), .indexed(indexed)
  );

  function automatic logic [1:0] exp_mode(logic [15:0] ins);
    if (ins[8]) return 2'b00;
    if (ins[7:0] >= 8'h60) return 2'b01;
    return 2'b10;
  endfunction

  function automatic logic [11:0] exp_addr(logic [15:0] ins, logic [3:0] bk, logic [11:0] p);
    logic [12:0] s;
    case (exp_mode(ins))
      2'b00: return {bk, ins[7:0]};
      2'b01: return {4'hF, ins[7:0]};
      default: begin
        s = {1'b0, p} + {5'b0, ins[7:0]};
        return s[11:0];
      end
    endcase
  endfunction

  task automatic check(input string tag);
    logic [11:0] ea;
    logic [1:0]  em;
    ea = exp_addr(instr, m_bank, {m_hi, m_lo});
    em = exp_mode(instr);
    checks++;
    if (addr !== ea || mode !== em || indexed !== (em == 2'b10)) begin
      errors++;
      $display("FAIL %s instr=%h addr=%h mode=%b idx=%b expected addr=%h mode=%b idx=%b",
               tag, instr, addr, mode, indexed, ea, em, em == 2'b10);
    end
  endtask

  task automatic load(input logic [3:0] bk, input logic [3:0] hi, input logic [7:0] lo);
    @(negedge clk);
    bank_we = 1; bank_wdata = bk;
    ptr_hi_we = 1; ptr_hi_wdata = hi;
    ptr_lo_we = 1; ptr_lo_wdata = lo;
    @(posedge clk);
    m_bank = bk; m_hi = hi; m_lo = lo;
    @(negedge clk);
    bank_we = 0; ptr_hi_we = 0; ptr_lo_we = 0;
  endtask

  task automatic apply(input logic [15:0] ins, input string tag);
    instr = ins;
    #1 check(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R5: registers zero after reset, seen through the banked and indexed paths
    @(negedge clk);
    apply(16'h25AB, "R5_bank_zero");
    apply(16'h2405, "R5_ptr_zero");

    load(4'h3, 4'h2, 8'h40);
    @(negedge clk);
    apply(16'h2512, "R1_direct");
    apply(16'h25FF, "R1_direct_ff");
    apply(16'h2460, "R2_forced_60");
    apply(16'h24FF, "R2_forced_ff");
    apply(16'h245F, "R3_indexed_5f");
    apply(16'h2400, "R3_indexed_00");
    // R7: opcode and destination bits ignored
    apply(16'hFE5F, "R7_high_bits_indexed");
    apply(16'h0260, "R7_high_bits_forced");
    apply(16'hDB77, "R7_high_bits_direct");

    // R4: wraparound
    load(4'hF, 4'hF, 8'hF0);
    @(negedge clk);
    apply(16'h245F, "R4_wrap");
    apply(16'h240F, "R4_wrap_edge");
    apply(16'h240E, "R4_no_wrap");

    // R8: independent halves
    @(negedge clk);
    ptr_lo_we = 1; ptr_lo_wdata = 8'h11;
    @(posedge clk); m_lo = 8'h11;
    @(negedge clk); ptr_lo_we = 0;
    apply(16'h2401, "R8_lo_only");
    ptr_hi_we = 1; ptr_hi_wdata = 4'h7;
    @(posedge clk); m_hi = 4'h7;
    @(negedge clk); ptr_hi_we = 0;
    apply(16'h2401, "R8_hi_only");

    // R6: same-cycle load not visible, disabled load ignored
    instr = 16'h2580;
    bank_we = 1; bank_wdata = 4'hA;
    #1 check("R6_same_cycle_old_bank");
    @(posedge clk); m_bank = 4'hA;
    @(negedge clk); bank_we = 0; bank_wdata = 4'h5;
    #1 check("R6_new_bank");
    @(posedge clk);
    @(negedge clk);
    #1 check("R6_disabled_hold");

    // random mix: R1 R2 R3 R6 R7 R9
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      bank_we = $urandom_range(0, 1); bank_wdata = 4'($urandom);
      ptr_hi_we = $urandom_range(0, 1); ptr_hi_wdata = 4'($urandom);
      ptr_lo_we = $urandom_range(0, 1); ptr_lo_wdata = 8'($urandom);
      instr = 16'($urandom);
      if ($urandom_range(0, 3) == 0) instr[7:0] = 8'h5F + 8'($urandom_range(0, 1));
      #1 check("R9_random");
      @(posedge clk);
      if (bank_we) m_bank = bank_wdata;
      if (ptr_hi_we) m_hi = ptr_hi_wdata;
      if (ptr_lo_we) m_lo = ptr_lo_wdata;
    end
    @(negedge clk);
    bank_we = 0; ptr_hi_we = 0; ptr_lo_we = 0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule